// File: doc/BRIEF.md
# 100BASE-TX Receive Physical Coding Sublayer

This block turns the retimed serial bit stream of a 100 Mb/s twisted-pair receiver into media-independent receive nibbles. Each accepted line bit, qualified by a one-cycle valid strobe, is first converted from NRZI to NRZ. It then passes through a self-synchronising descrambler built around an 11-bit LFSR and is shifted into a 10-bit serial-to-parallel window. That window is searched for the two-group start-of-stream delimiter. From the delimiter onward, every five bits form one code group, which is decoded to a 4-bit nibble with data-valid and error flags.

The descrambler acquires its key sequence from the line during idle, when the plain data is all ones. It stays locked only while idle keeps appearing. The frame logic runs only while the descrambler is locked. The outputs change only on edges where a line bit is accepted, and a one-cycle nibble strobe marks each new nibble. All other physical-layer functions sit upstream of this block.

Top module: `pcs100_rx`

## Requirements
- R1: While reset is asserted and after it is released, rxd_o, rx_dv_o, rx_er_o and nib_vld_o are 0 and the descrambler is unlocked.
- R2: A line bit accepted with bit_vld_i high decodes to NRZ 1 when it differs from the previously accepted line bit, and to 0 otherwise. The line level before the first accepted bit is taken as 0.
- R3: The key stream obeys key[n] = key[n-11] XOR key[n-9], and each plain bit is NRZ XOR key. The LFSR state resets to all zeros.
- R4: While unlocked, the LFSR is loaded with the inverted NRZ bits, which is the key if the plain data is idle ones. The predicted key is compared with the inverted NRZ bit. After LOCK_CNT consecutive correct predictions the block locks. Before lock, no frame is recognised and rx_dv_o stays 0.
- R5: While locked and outside a frame, a frame starts at the edge where the last ten descrambled bits equal 11000 then 10001 (first-received bit leftmost; each group is sent leftmost bit first). The delimiter produces no nibble. Each following 5 bits form one code group.
- R6: Data groups decode as follows. 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101. A data group sets rxd_o to the nibble, rx_dv_o to 1, rx_er_o to 0, and pulses nib_vld_o.
- R7: Inside a frame, any group that is neither data, 01101 nor 11111 sets rx_dv_o to 1, rx_er_o to 1 and rxd_o to 0, and pulses nib_vld_o.
- R8: Inside a frame, group 01101 or idle 11111 ends the frame. rxd_o, rx_dv_o and rx_er_o return to 0 without a nibble strobe, and the delimiter search resumes.
- R9: While locked, a count of LOSS_TMO consecutive accepted bits without completing a run of ten descrambled ones drops lock. The frame is cleared in the same edge: rx_dv_o, rx_er_o and rxd_o go to 0. Lock must then be reacquired as in R4.
- R10: rxd_o, rx_dv_o and rx_er_o change only on edges with bit_vld_i high. nib_vld_o is a single-cycle pulse.
- R11: A group's outputs appear in the cycle after the edge that accepts its fifth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Retimed NRZI line bit |
| bit_vld_i | input | 1 | bit_i is accepted on this edge |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Invalid code group inside frame |
| nib_vld_o | output | 1 | One-cycle strobe for a new nibble |

## Verification
The assertions check on every cycle the following properties:
- rx_dv_o is never high without descrambler lock.
- Lock is gained only on an accepted bit.
- The nibble outputs hold through cycles without a line bit.
- Nibble strobes never arrive back to back.

Only the bench's scenarios can show the rest:
- the decoded values;
- the delimiter search and its alignment;
- the end-of-frame handling;
- lock acquisition from idle, and lock loss after a long stretch without idle.

The bench shows these by scrambling and NRZI-encoding known frames and comparing every cycle against a behavioural model of the receive path.

// File: rtl/pcs100_rx_pkg.sv
package pcs100_rx_pkg;
  localparam int unsigned LFSR_W = 11;
  localparam int unsigned CG_W   = 5;
  localparam logic [2*CG_W-1:0] SSD = 10'b11000_10001;

  typedef enum logic [1:0] {CG_DATA, CG_END, CG_BAD} cg_kind_e;

  typedef struct packed {
    cg_kind_e   kind;
    logic [3:0] nib;
  } cg_dec_t;

  function automatic cg_dec_t cg_decode(input logic [CG_W-1:0] c);
    cg_dec_t r;
    r.kind = CG_DATA;
    r.nib  = 4'h0;
    case (c)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      5'b01101, 5'b11111: r.kind = CG_END;
      default: r.kind = CG_BAD;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcs100_nrzi_dec.sv
module pcs100_nrzi_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic line_i,
  output logic nrz_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= 1'b0;
    else if (vld_i) line_q <= line_i;
  end

  assign nrz_o = line_i ^ line_q;
endmodule

// File: rtl/pcs100_descrambler.sv
module pcs100_descrambler
  import pcs100_rx_pkg::*;
#(
  parameter int unsigned LOCK_CNT = 32,
  parameter int unsigned LOSS_TMO = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic nrz_i,
  output logic dat_o,
  output logic lock_o,
  output logic drop_o
);
  localparam int unsigned MW = $clog2(LOCK_CNT + 1);
  localparam int unsigned TW = $clog2(LOSS_TMO + 1);
  localparam logic [MW-1:0] LOCK_LAST = MW'(LOCK_CNT - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(LOSS_TMO - 1);
  localparam logic [3:0]    RUN_IDLE  = 4'd10;

  logic [LFSR_W-1:0] lfsr_q;
  logic [MW-1:0]     mcnt_q;
  logic [TW-1:0]     tmo_q;
  logic [3:0]        run_q, run_nxt;
  logic              lock_q, key, match, idle_now;

  assign key      = lfsr_q[10] ^ lfsr_q[8];
  assign dat_o    = nrz_i ^ key;
  assign match    = (key == ~nrz_i);
  assign idle_now = dat_o && (run_q >= RUN_IDLE - 4'd1);
  assign run_nxt  = !dat_o ? 4'd0 : (run_q == RUN_IDLE) ? RUN_IDLE : run_q + 4'd1;
  assign drop_o   = vld_i && lock_q && !idle_now && (tmo_q == TMO_LAST);
  assign lock_o   = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '0;
      mcnt_q <= '0;
      tmo_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (vld_i) begin
      if (!lock_q) begin
        // acquire: assume idle, so key == inverted line data
        lfsr_q <= {lfsr_q[LFSR_W-2:0], ~nrz_i};
        if (match) begin
          if (mcnt_q == LOCK_LAST) begin
            lock_q <= 1'b1;
            mcnt_q <= '0;
            tmo_q  <= '0;
            run_q  <= '0;
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end else begin
          mcnt_q <= '0;
        end
      end else begin
        lfsr_q <= {lfsr_q[LFSR_W-2:0], key};
        if (drop_o) begin
          lock_q <= 1'b0;
          run_q  <= '0;
          tmo_q  <= '0;
        end else begin
          run_q <= run_nxt;
          tmo_q <= idle_now ? '0 : tmo_q + 1'b1;
        end
      end
    end
  end

  p_lock_on_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(vld_i));
endmodule

// File: rtl/pcs100_align_dec.sv
module pcs100_align_dec
  import pcs100_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic       dat_i,
  input  logic       lock_i,
  input  logic       drop_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic       nib_vld_o
);
  logic [2*CG_W-1:0] sh_q, win;
  logic [2:0]        cnt_q;
  logic              frame_q;
  cg_dec_t           dec;

  assign win = {sh_q[2*CG_W-2:0], dat_i};
  assign dec = cg_decode(win[CG_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      frame_q   <= 1'b0;
      rxd_o     <= '0;
      rx_dv_o   <= 1'b0;
      rx_er_o   <= 1'b0;
      nib_vld_o <= 1'b0;
    end else begin
      nib_vld_o <= 1'b0;
      if (vld_i) begin
        sh_q <= win;
        if (!lock_i || drop_i) begin
          frame_q <= 1'b0;
          cnt_q   <= '0;
          rxd_o   <= '0;
          rx_dv_o <= 1'b0;
          rx_er_o <= 1'b0;
        end else if (!frame_q) begin
          if (win == SSD) begin
            frame_q <= 1'b1;
            cnt_q   <= '0;
          end
        end else if (cnt_q == 3'd4) begin
          cnt_q <= '0;
          case (dec.kind)
            CG_DATA: begin
              rxd_o <= dec.nib; rx_dv_o <= 1'b1; rx_er_o <= 1'b0; nib_vld_o <= 1'b1;
            end
            CG_BAD: begin
              rxd_o <= '0; rx_dv_o <= 1'b1; rx_er_o <= 1'b1; nib_vld_o <= 1'b1;
            end
            default: begin
              frame_q <= 1'b0;
              rxd_o <= '0; rx_dv_o <= 1'b0; rx_er_o <= 1'b0;
            end
          endcase
        end else begin
          cnt_q <= cnt_q + 3'd1;
        end
      end
    end
  end

  p_hold_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(rxd_o) && $stable(rx_dv_o) && $stable(rx_er_o)));

  p_nib_spacing_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |=> !nib_vld_o);
endmodule

// File: rtl/pcs100_rx.sv
module pcs100_rx #(
  parameter int unsigned LOCK_CNT = 32,
  parameter int unsigned LOSS_TMO = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic       nib_vld_o
);
  logic nrz, dat, lock, drop;

  pcs100_nrzi_dec u_nrzi (
    .clk_i (clk_i), .rst_ni (rst_ni), .vld_i (bit_vld_i),
    .line_i(bit_i), .nrz_o (nrz)
  );

  pcs100_descrambler #(.LOCK_CNT(LOCK_CNT), .LOSS_TMO(LOSS_TMO)) u_dscr (
    .clk_i (clk_i), .rst_ni (rst_ni), .vld_i (bit_vld_i), .nrz_i (nrz),
    .dat_o (dat), .lock_o (lock), .drop_o (drop)
  );

  pcs100_align_dec u_algn (
    .clk_i  (clk_i), .rst_ni (rst_ni), .vld_i (bit_vld_i), .dat_i (dat),
    .lock_i (lock), .drop_i (drop), .rxd_o (rxd_o), .rx_dv_o (rx_dv_o),
    .rx_er_o(rx_er_o), .nib_vld_o (nib_vld_o)
  );

  p_dv_needs_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |-> lock);
endmodule

// File: tb/pcs100_rx_test.sv
module pcs100_rx_test;
  localparam int LOCK_CNT = 24;
  localparam int LOSS_TMO = 400;
  localparam int JK = 10'b1100010001;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic [3:0] rxd_o;
  logic       rx_dv_o, rx_er_o, nib_vld_o;

  pcs100_rx #(.LOCK_CNT(LOCK_CNT), .LOSS_TMO(LOSS_TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .rxd_o(rxd_o), .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .nib_vld_o(nib_vld_o)
  );

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  int gap_mode = 0;

  // 4B/5B data groups, index = nibble
  int code_tab[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                       5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                       5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // transmitter side
  int tx_k[$];
  bit tx_line = 0;

  // receive reference model
  int  m_h[$];
  bit  m_prev = 0, m_lk = 0, m_fr = 0;
  int  m_mcnt = 0, m_tmo = 0, m_run = 0, m_cnt = 0, m_w = 0;
  int  e_rxd = 0;
  bit  e_dv = 0, e_er = 0, e_nv = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check();
    n_vec++;
    if (rxd_o !== 4'(e_rxd) || rx_dv_o !== e_dv || rx_er_o !== e_er || nib_vld_o !== e_nv) begin
      n_bad++;
      $display("FAIL %s t=%0t act rxd=%h dv=%b er=%b nv=%b exp rxd=%h dv=%b er=%b nv=%b",
               tag, $time, rxd_o, rx_dv_o, rx_er_o, nib_vld_o, 4'(e_rxd), e_dv, e_er, e_nv);
    end
  endtask

  function automatic void model_bit(bit b);
    bit nrz, pred, d, lk0, drop;
    int g, nib, kind;
    nrz = b ^ m_prev; m_prev = b;
    lk0 = m_lk; drop = 0;
    pred = 1'(m_h[m_h.size()-11] ^ m_h[m_h.size()-9]);
    d = nrz ^ pred;
    if (!m_lk) begin
      m_h.push_back(int'(!nrz));
      if (pred == !nrz) begin
        m_mcnt++;
        if (m_mcnt == LOCK_CNT) begin m_lk = 1; m_mcnt = 0; m_tmo = 0; m_run = 0; end
      end else m_mcnt = 0;
    end else begin
      m_h.push_back(int'(pred));
      m_run = d ? ((m_run + 1 > 10) ? 10 : m_run + 1) : 0;
      if (m_run >= 10) m_tmo = 0;
      else begin
        m_tmo++;
        if (m_tmo == LOSS_TMO) begin drop = 1; m_lk = 0; m_run = 0; m_tmo = 0; end
      end
    end
    while (m_h.size() > 11) void'(m_h.pop_front());
    m_w = ((m_w << 1) | int'(d)) & 1023;
    e_nv = 0;
    if (!lk0 || drop) begin
      m_fr = 0; m_cnt = 0; e_dv = 0; e_er = 0; e_rxd = 0;
    end else if (!m_fr) begin
      if (m_w == JK) begin m_fr = 1; m_cnt = 0; end
    end else if (m_cnt == 4) begin
      m_cnt = 0; g = m_w & 31; kind = 2; nib = 0;
      for (int i = 0; i < 16; i++) if (code_tab[i] == g) begin kind = 0; nib = i; end
      if (g == 5'b01101 || g == 5'b11111) kind = 1;
      if (kind == 0) begin e_rxd = nib; e_dv = 1; e_er = 0; e_nv = 1; end
      else if (kind == 2) begin e_rxd = 0; e_dv = 1; e_er = 1; e_nv = 1; end
      else begin m_fr = 0; e_rxd = 0; e_dv = 0; e_er = 0; end
    end else m_cnt++;
  endfunction

  task automatic idle_cyc();
    @(negedge clk); check();
    bit_vld_i = 1'b0; e_nv = 0;
  endtask

  task automatic send_bit(bit plain);
    int key;
    bit scr;
    key = tx_k[tx_k.size()-11] ^ tx_k[tx_k.size()-9];
    tx_k.push_back(key); void'(tx_k.pop_front());
    scr = plain ^ 1'(key);
    tx_line = tx_line ^ scr;
    @(negedge clk); check();
    bit_vld_i = 1'b1; bit_i = tx_line;
    model_bit(tx_line);
    if (gap_mode != 0) for (int i = 0; i < (n_vec % 3); i++) idle_cyc();
  endtask

  task automatic send_grp(int c);
    for (int i = 4; i >= 0; i--) send_bit(1'((c >> i) & 1));
  endtask

  task automatic send_idle(int n);
    for (int i = 0; i < n; i++) send_grp(5'b11111);
  endtask

  task automatic send_nib(int n);
    send_grp(code_tab[n & 15]);
  endtask

  task automatic send_ssd();
    send_grp(5'b11000); send_grp(5'b10001);
  endtask

  task automatic send_end();
    send_grp(5'b01101); send_grp(5'b00111);
  endtask

  initial begin
    for (int i = 0; i < 11; i++) begin m_h.push_back(0); tx_k.push_back(1); end
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    check();
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) idle_cyc();

    tag = "R4 before lock";
    send_ssd(); send_nib(1); send_nib(2); send_end();
    send_idle(16);

    tag = "R5 R6 all nibbles";
    send_ssd();
    for (int i = 0; i < 16; i++) send_nib(i);
    send_end(); send_idle(4);

    tag = "R7 R11 invalid groups";
    send_ssd(); send_nib(3); send_grp(5'b00000); send_nib(7); send_grp(5'b00100);
    send_grp(5'b11000); send_nib(9); send_end(); send_idle(4);

    tag = "R8 end on idle";
    send_ssd(); send_nib(10); send_nib(11); send_idle(6);

    tag = "R10 strobe gaps";
    gap_mode = 1;
    send_ssd(); send_nib(12); send_nib(4); send_grp(5'b00001); send_nib(13); send_end();
    send_idle(4);
    gap_mode = 0;

    tag = "R2 R3 mixed data";
    send_ssd();
    for (int i = 0; i < 32; i++) send_nib((i * 7 + 5) % 16);
    send_end(); send_idle(4);

    tag = "R9 lock loss";
    send_ssd();
    for (int i = 0; i < 120; i++) send_nib(5);
    send_end();
    tag = "R9 R4 relock";
    send_idle(20);
    send_ssd(); send_nib(1); send_nib(14); send_nib(6); send_end(); send_idle(3);

    idle_cyc();
    @(negedge clk); check();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule